// File: doc/BRIEF.md
# Decoded RAM/ROM Byte Store

This block is a small byte-wide memory subsystem hanging off a 16-bit address bus. It contains four 128-byte read/write devices and one 512-byte read-only device. The address is decoded into a per-device select, and a shared active-low bus strobe provides each device's second select. A device acts only when both of its selects are asserted. Each device then runs its own access function table, in which a read request takes priority over a write request.

The bidirectional data bus is split into three ports: a write-data input, a read-data output, and an output-enable flag that stands for the bus being driven. When no device drives the bus, the read-data output is held at zero. Writes are taken on the rising clock edge. Reads are combinational, and the output enable rises in the same cycle as the request. The read-only image is a parameter computed at elaboration.

Each device sorts every cycle into one of three named access states. INHIBIT is taken when the device is not selected, or when it is selected with neither request raised. WRITE is taken when the device is selected, the read request is low and the write request is high. READ is taken when the device is selected and the read request is high, whatever the write request is. No transition is registered: the state follows the inputs in each cycle. A device in WRITE stores the byte at the next rising edge. On the read-only device, WRITE does nothing.

Top module: `mem_subsys`

## Requirements
- R1: While `rst_n` is low, all 512 read/write bytes are cleared to 00. After reset, a read from any read/write address returns 00 until that address is written.
- R2: A device can be selected only when `bus_sel_n` is 0 and `addr[15:10]` is all zero. Otherwise `dout_en` is 0 and no byte is written.
- R3: When `addr[9]` is 0, the read/write device numbered `addr[8:7]` is selected and `addr[6:0]` is the byte offset. Device 0 covers 0000-007F, device 1 covers 0080-00FF, device 2 covers 0100-017F and device 3 covers 0180-01FF.
- R4: When `addr[9]` is 1, the read-only device is selected and `addr[8:0]` is the offset k. It holds the byte ((29*k + 90) mod 256) XOR (k >> 8).
- R5: When a device is selected and `rd` is 1, `dout` carries the addressed byte and `dout_en` is 1 in the same cycle. `wr` is ignored, and the byte is not changed.
- R6: When a read/write device is selected with `rd` 0 and `wr` 1, `din` is stored at the addressed byte on the rising clock edge. A read in the following cycle returns that byte.
- R7: When a device is selected with `rd` 0 and `wr` 0, the device is inhibited: `dout_en` is 0 and no byte changes.
- R8: A write request to a read-only address has no effect. A later read of that address returns the image byte.
- R9: Whenever `dout_en` is 0, `dout` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears read/write bytes |
| addr | input | 16 | Bus address |
| bus_sel_n | input | 1 | Shared active-low select, second select of every device |
| rd | input | 1 | Read request, has priority over write |
| wr | input | 1 | Write request |
| din | input | 8 | Byte from the bus into the memory |
| dout | output | 8 | Byte from the memory onto the bus, 00 when not driven |
| dout_en | output | 1 | High when a device drives the bus |

## Verification
The assertions check four things on every cycle. At most one device drives the bus. The bus is never driven without the strobe and a read request. An undriven bus reads 00. A write to the read-only range never drives the bus. Inside each read/write device, a WRITE cycle must leave `din` at the addressed byte, and any other cycle must leave that byte unchanged. The bench's scenarios cover the rest, because those behaviours depend on history. Examples are the contents after reset, the exact byte range of each device, read priority leaving the byte intact, and writes to aliased upper addresses or read-only addresses leaving the whole map untouched. A behavioural byte map of 0000-03FF gives the expected value for each of these.

// File: rtl/mem_pkg.sv
package mem_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int RAM_AW   = 7;
    localparam int N_RAM    = 4;
    localparam int ROM_AW   = 9;
    localparam int ROM_SIZE = 1 << ROM_AW;

    typedef logic [DATA_W-1:0] byte_t;
    typedef byte_t rom_img_t [ROM_SIZE];

    // access state of one device in one cycle
    typedef enum logic [1:0] {
        ACC_INHIBIT = 2'd0,
        ACC_WRITE   = 2'd1,
        ACC_READ    = 2'd2
    } acc_state_t;

    // read wins over write; both selects must be active
    function automatic acc_state_t classify(input logic sel_hi, input logic sel_lo_n,
                                            input logic rd_req, input logic wr_req);
        acc_state_t s;
        if (!(sel_hi && !sel_lo_n)) s = ACC_INHIBIT;
        else if (rd_req)            s = ACC_READ;
        else if (wr_req)            s = ACC_WRITE;
        else                        s = ACC_INHIBIT;
        return s;
    endfunction

    // read-only image: ((29*k + 90) mod 256) xor (k >> 8)
    function automatic rom_img_t rom_pattern();
        rom_img_t img;
        for (int k = 0; k < ROM_SIZE; k++) begin
            img[k] = byte_t'((k * 29 + 90) & 255) ^ byte_t'(k >> 8);
        end
        return img;
    endfunction

endpackage

// File: rtl/mem_decode.sv
module mem_decode
    import mem_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int RAM_AW_P = RAM_AW,
    parameter int N_RAM_P = N_RAM,
    parameter int ROM_AW_P = ROM_AW
) (
    input  logic [AW-1:0]      addr,
    output logic [N_RAM_P-1:0] ram_hit,
    output logic               rom_hit
);
    localparam int SEL_W  = $clog2(N_RAM_P);
    localparam int HI_LSB = ROM_AW_P + 1;

    logic upper_zero;
    logic space_rom;
    logic [SEL_W-1:0] dev_idx;

    always_comb begin
        upper_zero = (addr[AW-1:HI_LSB] == '0);
        space_rom  = addr[ROM_AW_P];
        dev_idx    = addr[RAM_AW_P +: SEL_W];
    end

    assign rom_hit = upper_zero && space_rom;

    for (genvar g = 0; g < N_RAM_P; g++) begin : g_hit
        assign ram_hit[g] = upper_zero && !space_rom && (dev_idx == SEL_W'(g));
    end

endmodule

// File: rtl/ram_dev.sv
module ram_dev
    import mem_pkg::*;
#(
    parameter int AW = RAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_hi,
    input  logic          sel_lo_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          oe
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    acc_state_t    acc;

    always_comb acc = classify(sel_hi, sel_lo_n, rd, wr);

    // output process
    always_comb begin
        oe   = 1'b0;
        dout = '0;
        unique case (acc)
            ACC_READ: begin
                oe   = 1'b1;
                dout = mem[addr];
            end
            ACC_WRITE:   ;
            ACC_INHIBIT: ;
            default:     ;
        endcase
    end

    // storage process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (acc == ACC_WRITE) begin
            mem[addr] <= din;
        end
    end

    // R6: a WRITE cycle lands din at the addressed byte
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_hi && !sel_lo_n && !rd && wr) |=> (mem[$past(addr)] == $past(din)));

    // R5/R7: any other cycle leaves the addressed byte unchanged
    assert_byte_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_hi && !sel_lo_n && !rd && wr) |=> (mem[$past(addr)] == $past(mem[addr])));

endmodule

// File: rtl/rom_dev.sv
module rom_dev
    import mem_pkg::*;
#(
    parameter int       AW    = ROM_AW,
    parameter rom_img_t IMAGE = rom_pattern()
) (
    input  logic          sel_hi,
    input  logic          sel_lo_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output byte_t         dout,
    output logic          oe
);
    acc_state_t acc;

    always_comb acc = classify(sel_hi, sel_lo_n, rd, wr);

    always_comb begin
        oe   = 1'b0;
        dout = '0;
        unique case (acc)
            ACC_READ: begin
                oe   = 1'b1;
                dout = IMAGE[addr];
            end
            ACC_WRITE:   ;   // read-only: write request dropped
            ACC_INHIBIT: ;
            default:     ;
        endcase
    end

endmodule

// File: rtl/mem_subsys.sv
module mem_subsys
    import mem_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int DW        = DATA_W,
    parameter int RAM_AW_P  = RAM_AW,
    parameter int N_RAM_P   = N_RAM,
    parameter int ROM_AW_P  = ROM_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   addr,
    input  logic          bus_sel_n,
    input  logic          rd,
    input  logic          wr,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic          dout_en
);
    localparam int N_DEV = N_RAM_P + 1;

    logic [N_RAM_P-1:0] ram_hit;
    logic               rom_hit;
    logic [N_DEV-1:0]   dev_oe;
    logic [DW-1:0]      dev_data [N_DEV];

    mem_decode #(
        .AW(AW), .RAM_AW_P(RAM_AW_P), .N_RAM_P(N_RAM_P), .ROM_AW_P(ROM_AW_P)
    ) u_dec (
        .addr    (addr),
        .ram_hit (ram_hit),
        .rom_hit (rom_hit)
    );

    for (genvar g = 0; g < N_RAM_P; g++) begin : g_ram
        ram_dev #(.AW(RAM_AW_P), .DW(DW)) u_ram (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_hi   (ram_hit[g]),
            .sel_lo_n (bus_sel_n),
            .rd       (rd),
            .wr       (wr),
            .addr     (addr[RAM_AW_P-1:0]),
            .din      (din),
            .dout     (dev_data[g]),
            .oe       (dev_oe[g])
        );
    end

    rom_dev #(.AW(ROM_AW_P)) u_rom (
        .sel_hi   (rom_hit),
        .sel_lo_n (bus_sel_n),
        .rd       (rd),
        .wr       (wr),
        .addr     (addr[ROM_AW_P-1:0]),
        .dout     (dev_data[N_RAM_P]),
        .oe       (dev_oe[N_RAM_P])
    );

    // bus merge: at most one device drives
    always_comb begin
        dout    = '0;
        dout_en = |dev_oe;
        for (int i = 0; i < N_DEV; i++) begin
            if (dev_oe[i]) dout = dout | dev_data[i];
        end
    end

    // R3: one driver at most
    assert_one_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_oe));

    // R2/R5: bus driven only with strobe, clean upper bits and a read
    assert_oe_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!bus_sel_n && rd && addr[15:10] == 6'd0));

    // R9: undriven bus reads zero
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

    // R8: write to read-only range never drives the bus
    assert_rom_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_hit && !rd && wr) |-> !dout_en);

endmodule

// File: tb/tb_mem_subsys.sv
`timescale 1ns/1ps
module tb_mem_subsys;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr;
    logic        bus_sel_n;
    logic        rd;
    logic        wr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    logic [7:0] ref_mem [1024];

    always #4 clk = ~clk;

    mem_subsys dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bus_sel_n(bus_sel_n),
        .rd(rd), .wr(wr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] rom_byte(input int k);
        return 8'((k * 29 + 90) % 256) ^ 8'(k >> 8);
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            report();
        end
    end

    // one bus cycle: drive at negedge, compare, update model after the edge
    task automatic apply(input logic [15:0] a, input logic sn, input logic r,
                         input logic w, input logic [7:0] d, input string tag);
        logic       sel;
        logic       exp_oe;
        logic [7:0] exp_d;
        @(negedge clk);
        addr = a; bus_sel_n = sn; rd = r; wr = w; din = d;
        #1;
        sel    = !sn && (a[15:10] == 6'd0);
        exp_oe = sel && r;
        exp_d  = exp_oe ? ref_mem[a[9:0]] : 8'h00;
        vectors++;
        if (dout_en !== exp_oe || dout !== exp_d) begin
            miscompares++;
            $display("FAIL %s addr=%h: actual oe=%b dout=%h, expected oe=%b dout=%h",
                     tag, a, dout_en, dout, exp_oe, exp_d);
        end
        @(posedge clk);
        if (sel && !r && w && !a[9]) ref_mem[a[9:0]] = d;
    endtask

    initial begin
        for (int k = 0; k < 512; k++) ref_mem[k] = 8'h00;
        for (int k = 0; k < 512; k++) ref_mem[512 + k] = rom_byte(k);
        rst_n = 1'b0; addr = '0; bus_sel_n = 1'b1; rd = 1'b0; wr = 1'b0; din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: contents after reset; R4 image
        for (int k = 0; k < 1024; k += 37) apply(16'(k), 1'b0, 1'b1, 1'b0, 8'h00, "R1/R4 post-reset read");
        apply(16'h01FF, 1'b0, 1'b1, 1'b0, 8'h00, "R1 last ram byte");
        apply(16'h0200, 1'b0, 1'b1, 1'b0, 8'h00, "R4 first rom byte");
        apply(16'h03FF, 1'b0, 1'b1, 1'b0, 8'h00, "R4 last rom byte");

        // R3/R6: device boundaries written then read
        apply(16'h0000, 1'b0, 1'b0, 1'b1, 8'hA1, "R6 write dev0 low");
        apply(16'h007F, 1'b0, 1'b0, 1'b1, 8'hA2, "R6 write dev0 high");
        apply(16'h0080, 1'b0, 1'b0, 1'b1, 8'hB1, "R6 write dev1 low");
        apply(16'h00FF, 1'b0, 1'b0, 1'b1, 8'hB2, "R6 write dev1 high");
        apply(16'h0100, 1'b0, 1'b0, 1'b1, 8'hC1, "R6 write dev2 low");
        apply(16'h017F, 1'b0, 1'b0, 1'b1, 8'hC2, "R6 write dev2 high");
        apply(16'h0180, 1'b0, 1'b0, 1'b1, 8'hD1, "R6 write dev3 low");
        apply(16'h01FF, 1'b0, 1'b0, 1'b1, 8'hD2, "R6 write dev3 high");
        for (int k = 0; k < 4; k++) begin
            apply(16'(k * 128),       1'b0, 1'b1, 1'b0, 8'h00, "R3 device range low");
            apply(16'(k * 128 + 127), 1'b0, 1'b1, 1'b0, 8'h00, "R3 device range high");
            apply(16'(k * 128 + 1),   1'b0, 1'b1, 1'b0, 8'h00, "R3 neighbour untouched");
        end

        // R5: read with write raised, byte must stay
        apply(16'h0080, 1'b0, 1'b1, 1'b1, 8'h55, "R5 read priority");
        apply(16'h0080, 1'b0, 1'b1, 1'b0, 8'h00, "R5 byte unchanged");

        // R7: selected but idle
        apply(16'h0100, 1'b0, 1'b0, 1'b0, 8'h77, "R7 inhibit");
        apply(16'h0100, 1'b0, 1'b1, 1'b0, 8'h00, "R7 byte unchanged");

        // R2: strobe high blocks read and write
        apply(16'h0000, 1'b1, 1'b1, 1'b0, 8'h00, "R2 strobe off read");
        apply(16'h0000, 1'b1, 1'b0, 1'b1, 8'h3C, "R2 strobe off write");
        apply(16'h0000, 1'b0, 1'b1, 1'b0, 8'h00, "R2 strobe off no write");
        // R2: upper address bits set alias nothing
        apply(16'h0400, 1'b0, 1'b1, 1'b0, 8'h00, "R2 upper bits read");
        apply(16'h8180, 1'b0, 1'b0, 1'b1, 8'h66, "R2 upper bits write");
        apply(16'h0180, 1'b0, 1'b1, 1'b0, 8'h00, "R2 alias untouched");
        apply(16'hFFFF, 1'b0, 1'b1, 1'b0, 8'h00, "R2 top address");

        // R8: writes into read-only range
        apply(16'h0200, 1'b0, 1'b0, 1'b1, 8'h00, "R8 rom write");
        apply(16'h0345, 1'b0, 1'b0, 1'b1, 8'hFF, "R8 rom write");
        apply(16'h0200, 1'b0, 1'b1, 1'b0, 8'h00, "R8 rom unchanged");
        apply(16'h0345, 1'b0, 1'b1, 1'b0, 8'h00, "R8 rom unchanged");

        // R6/R9: full sweep with mixed control
        for (int k = 0; k < 512; k++) apply(16'(k), 1'b0, 1'b0, 1'b1, 8'((k * 7) ^ 8'h5A), "R6 sweep write");
        for (int k = 0; k < 1024; k++) apply(16'(k), 1'b0, 1'b1, 1'b0, 8'h00, "R6/R4 sweep read");
        for (int k = 0; k < 64; k++) apply(16'(k * 16), k[0], k[1], k[2], 8'(k), "R9 mixed control");

        report();
    end

endmodule